// File: doc/BRIEF.md
# List-Mode Event Record Formatter

This block turns each gated acquisition window into a self-describing run of 32-bit words for the list-mode event store. When any gate opens while acquisition is armed, it takes a snapshot of a free-running 48-bit timestamp and starts watching every channel. For each channel it keeps the largest conversion seen during the window and counts how many conversions arrived. When the last gate closes, the event counter advances by one and the record is written out one word per clock: a header, two timestamp words, one word per reported channel, and a trailer that carries the event count.

The write side is a linear address counter over a memory of `2**ADDR_W` longwords. It raises a half-full flag at the midpoint and a full flag when fewer than `FULL_MARGIN` longwords remain. Full drops the arm state so that later events are refused. A record that is already in flight is truncated at the last location, so the memory never wraps. A zero-enable mode makes every record list all channels, which gives a fixed record length. Conversion, the analogue front end and bus access are handled by neighbouring logic.

Top module: `evrec_formatter`

## Requirements
- R1: Bits 26:24 of every written word give its kind: 2 for the header, 5 for the upper timestamp word, 6 for the lower timestamp word, 0 for a channel word and 4 for the trailer. A record is written in the order header, upper timestamp, lower timestamp, channel words by ascending channel, trailer.
- R2: The header holds `user_id` in bits 23:16 and the number of channel words that follow in bits 11:8. All its other bits are zero.
- R3: A channel word holds the number of conversions seen during the window in bits 31:28, the channel number in bits 18:16 (0 is the first channel) and the largest conversion value of the window in bits 12:0. All its other bits are zero. Only conversions that arrive while the record is open and a gate is high are counted.
- R4: The per-channel conversion count saturates at 15.
- R5: With `zero_en` high, every record lists all 8 channels and the header count is 8 (binary 1000). A channel that saw no conversion is listed with a zero count and a zero value. With `zero_en` low, only channels that converted are listed, so a window with no conversion gives a 4-word record.
- R6: The timestamp advances by one on each cycle with `ts_tick` high. The value it holds on the clock edge where the first gate opens is recorded, with bits 47:24 in the low 24 bits of the upper word and bits 23:0 in the low 24 bits of the lower word.
- R7: `ts_clr` resets the timestamp to zero only while `arm` is low. While armed it has no effect.
- R8: `event_count` rises by exactly one for each accepted window, however the master gate and the channel gates overlap. The trailer carries the updated count in bits 23:0.
- R9: A gate that opens while `arm` is low, or while a previous record is still being written, starts no record and leaves `event_count` unchanged.
- R10: Words are written at consecutive addresses starting from 0. Clearing `arm` does not move the address.
- R11: `half_full` is high once `wr_addr` has reached half the memory depth.
- R12: `full` is high once fewer than `FULL_MARGIN` longwords remain past `wr_addr`. On the next clock `arm` is cleared, and it stays low even if `arm_set` is pulsed.
- R13: Once the last memory location has been written, no further write occurs and `wr_addr` holds at the last location.
- R14: After reset, `arm`, `wr_en`, `wr_addr`, `event_count`, `half_full` and `full` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_set | input | 1 | Pulse that arms acquisition |
| arm_clr | input | 1 | Pulse that disarms acquisition |
| arm | output | 1 | Acquisition armed |
| ts_tick | input | 1 | Timestamp count enable (one per timestamp period) |
| ts_clr | input | 1 | Timestamp clear request, honoured only while disarmed |
| master_gate | input | 1 | Gate common to all channels |
| chan_gate | input | NCH | Per-channel gates |
| conv_valid | input | NCH | Per-channel conversion strobe |
| conv_value | input | NCH*ADC_W | Per-channel conversion values, channel 0 in the low bits |
| user_id | input | 8 | Identifier copied into each header |
| zero_en | input | 1 | List all channels in every record |
| wr_addr | output | ADDR_W | Address of the word on `wr_data` |
| wr_data | output | 32 | Record word |
| wr_en | output | 1 | Write strobe for `wr_data` at `wr_addr` |
| event_count | output | 24 | Accepted-event counter |
| half_full | output | 1 | Memory half used |
| full | output | 1 | Fewer than `FULL_MARGIN` longwords free |

## Verification
The hardest state to reach is a record that starts with exactly `FULL_MARGIN` longwords free, so that full rises in the middle of the record and the record then runs into the last location. The bench builds the block with a 128-word memory. After the table-driven events, it tracks the expected address and sizes each further record from the channel mask and the zero-enable setting, so that the last record starts exactly at that boundary. It then checks the truncated record, the flags and the refused re-arm.

// File: rtl/evrec_pkg.sv
package evrec_pkg;

   localparam int WORD_W       = 32;
   localparam int UID_W        = 8;
   localparam int EVC_W        = 24;
   localparam int TS_W         = 48;
   localparam int VAL_FIELD_W  = 13;
   localparam int PILE_FIELD_W = 4;
   localparam int NUM_FIELD_W  = 4;
   localparam int CHN_FIELD_W  = 3;

   typedef logic [2:0] wkind_t;

   localparam wkind_t WK_CHAN = 3'd0;
   localparam wkind_t WK_HDR  = 3'd2;
   localparam wkind_t WK_TRL  = 3'd4;
   localparam wkind_t WK_TSH  = 3'd5;
   localparam wkind_t WK_TSL  = 3'd6;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CAPT,
      ST_HDR,
      ST_TSH,
      ST_TSL,
      ST_CHN,
      ST_TRL
   } step_t;

   function automatic logic [WORD_W-1:0] pack_hdr(
      input logic [UID_W-1:0]       uid,
      input logic [NUM_FIELD_W-1:0] num
   );
      return {5'd0, WK_HDR, uid, 4'd0, num, 8'd0};
   endfunction

   function automatic logic [WORD_W-1:0] pack_ts(
      input wkind_t      kind,
      input logic [23:0] bits
   );
      return {5'd0, kind, bits};
   endfunction

   function automatic logic [WORD_W-1:0] pack_chan(
      input logic [PILE_FIELD_W-1:0] pile,
      input logic [CHN_FIELD_W-1:0]  chn,
      input logic [VAL_FIELD_W-1:0]  val
   );
      return {pile, 1'b0, WK_CHAN, 5'd0, chn, 3'd0, val};
   endfunction

   function automatic logic [WORD_W-1:0] pack_trl(
      input logic [EVC_W-1:0] cnt
   );
      return {5'd0, WK_TRL, cnt};
   endfunction

endpackage

// File: rtl/evrec_chan_track.sv
module evrec_chan_track #(
   parameter int ADC_W  = 13,
   parameter int PILE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              acc,
   input  logic              in_valid,
   input  logic [ADC_W-1:0]  in_value,
   output logic              hit,
   output logic [PILE_W-1:0] pile,
   output logic [ADC_W-1:0]  peak
);

   localparam logic [PILE_W-1:0] PILE_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pile <= '0;
         peak <= '0;
      end else if (clr) begin
         pile <= '0;
         peak <= '0;
      end else if (acc && in_valid) begin
         if (pile != PILE_MAX) begin
            pile <= pile + 1'b1;
         end
         if (in_value > peak) begin
            peak <= in_value;
         end
      end
   end

   assign hit = |pile;

   // R4
   pile_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (pile >= $past(pile)));

   // R3
   peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (peak >= $past(peak)));

endmodule

// File: rtl/evrec_stamp.sv
module evrec_stamp #(
   parameter int TS_W = 48
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            clr_req,
   input  logic            armed,
   input  logic            latch,
   output logic [TS_W-1:0] stamp
);

   logic [TS_W-1:0] count;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr_req && !armed) begin
         count <= '0;
      end else if (tick) begin
         count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stamp <= '0;
      end else if (latch) begin
         stamp <= count;
      end
   end

   // R7
   ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !tick) |=> (count == $past(count)));

   // R6
   stamp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !latch |=> $stable(stamp));

endmodule

// File: rtl/evrec_store.sv
module evrec_store #(
   parameter int ADDR_W      = 19,
   parameter int FULL_MARGIN = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid,
   input  logic [31:0]       word,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data,
   output logic              wr_en,
   output logic              half_full,
   output logic              full
);

   localparam int DEPTH    = 1 << ADDR_W;
   localparam int FULL_THR = DEPTH - FULL_MARGIN;

   localparam logic [ADDR_W-1:0] TOP_ADDR  = '1;
   localparam logic [ADDR_W-1:0] HALF_ADDR = ADDR_W'(DEPTH / 2);
   localparam logic [ADDR_W-1:0] FULL_A    = ADDR_W'(FULL_THR);
   localparam logic [ADDR_W-1:0] ONE_A     = ADDR_W'(1);

   if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_addr_w
      $error("evrec_store: ADDR_W must lie in 4..24");
   end
   if (FULL_MARGIN < 1 || FULL_MARGIN >= DEPTH / 2) begin : g_bad_margin
      $error("evrec_store: FULL_MARGIN must lie below half the depth");
   end

   logic top_q;
   logic at_top_wr;
   logic top_next;

   assign at_top_wr = wr_en && (wr_addr == TOP_ADDR);
   assign top_next  = top_q || at_top_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_addr <= '0;
         wr_data <= '0;
         wr_en   <= 1'b0;
         top_q   <= 1'b0;
      end else begin
         wr_en <= word_valid && !top_next;
         if (word_valid && !top_next) begin
            wr_data <= word;
         end
         if (at_top_wr) begin
            top_q <= 1'b1;
         end else if (wr_en) begin
            wr_addr <= wr_addr + ONE_A;
         end
      end
   end

   assign half_full = top_q || (wr_addr >= HALF_ADDR);
   assign full      = top_q || (wr_addr > FULL_A);

   // R13
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      top_q |-> !wr_en);

   // R10
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr != TOP_ADDR)) |=> (wr_addr == $past(wr_addr) + ONE_A));

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(wr_addr));

   // R11
   half_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      half_full |=> half_full);

endmodule

// File: rtl/evrec_formatter.sv
module evrec_formatter
   import evrec_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int ADC_W       = 13,
   parameter int PILE_W      = 4,
   parameter int ADDR_W      = 19,
   parameter int FULL_MARGIN = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 arm_set,
   input  logic                 arm_clr,
   output logic                 arm,
   input  logic                 ts_tick,
   input  logic                 ts_clr,
   input  logic                 master_gate,
   input  logic [NCH-1:0]       chan_gate,
   input  logic [NCH-1:0]       conv_valid,
   input  logic [NCH*ADC_W-1:0] conv_value,
   input  logic [UID_W-1:0]     user_id,
   input  logic                 zero_en,
   output logic [ADDR_W-1:0]    wr_addr,
   output logic [WORD_W-1:0]    wr_data,
   output logic                 wr_en,
   output logic [EVC_W-1:0]     event_count,
   output logic                 half_full,
   output logic                 full
);

   localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;
   localparam logic [CH_W-1:0]  CH_LAST = CH_W'(NCH - 1);
   localparam logic [EVC_W-1:0] EVC_ONE = EVC_W'(1);

   if (NCH < 1 || NCH > 8) begin : g_bad_nch
      $error("evrec_formatter: NCH must lie in 1..8");
   end
   if (ADC_W < 1 || ADC_W > VAL_FIELD_W) begin : g_bad_adc_w
      $error("evrec_formatter: ADC_W exceeds the value field");
   end
   if (PILE_W < 1 || PILE_W > PILE_FIELD_W) begin : g_bad_pile_w
      $error("evrec_formatter: PILE_W exceeds the count field");
   end

   step_t                  st, st_nx;
   logic [CH_W-1:0]        ch_idx, ch_nx;
   logic                   gate_any, gate_q;
   logic                   start, acc_en;
   logic [TS_W-1:0]        stamp;
   logic [NCH-1:0]         hits;
   logic [PILE_W-1:0]      pile_a [NCH];
   logic [ADC_W-1:0]       peak_a [NCH];
   logic [NUM_FIELD_W-1:0] n_conv, rep_cnt;
   logic                   w_valid;
   logic [WORD_W-1:0]      w_data;

   assign gate_any = master_gate || (|chan_gate);
   assign start    = (st == ST_IDLE) && arm && gate_any && !gate_q;
   assign acc_en   = (st == ST_CAPT) && gate_any;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      evrec_chan_track #(
         .ADC_W  (ADC_W),
         .PILE_W (PILE_W)
      ) i_trk (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (start),
         .acc      (acc_en),
         .in_valid (conv_valid[c]),
         .in_value (conv_value[c*ADC_W +: ADC_W]),
         .hit      (hits[c]),
         .pile     (pile_a[c]),
         .peak     (peak_a[c])
      );
   end

   evrec_stamp #(
      .TS_W (TS_W)
   ) i_stamp (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (ts_tick),
      .clr_req (ts_clr),
      .armed   (arm),
      .latch   (start),
      .stamp   (stamp)
   );

   always_comb begin
      n_conv = '0;
      for (int i = 0; i < NCH; i++) begin
         n_conv = n_conv + {{(NUM_FIELD_W-1){1'b0}}, hits[i]};
      end
      rep_cnt = zero_en ? NUM_FIELD_W'(NCH) : n_conv;
   end

   always_comb begin
      st_nx   = st;
      ch_nx   = ch_idx;
      w_valid = 1'b0;
      w_data  = '0;
      unique case (st)
         ST_IDLE: begin
            if (start) st_nx = ST_CAPT;
         end
         ST_CAPT: begin
            if (!gate_any) st_nx = ST_HDR;
         end
         ST_HDR: begin
            w_valid = 1'b1;
            w_data  = pack_hdr(user_id, rep_cnt);
            st_nx   = ST_TSH;
         end
         ST_TSH: begin
            w_valid = 1'b1;
            w_data  = pack_ts(WK_TSH, stamp[47:24]);
            st_nx   = ST_TSL;
         end
         ST_TSL: begin
            w_valid = 1'b1;
            w_data  = pack_ts(WK_TSL, stamp[23:0]);
            st_nx   = ST_CHN;
            ch_nx   = '0;
         end
         ST_CHN: begin
            w_valid = zero_en || hits[ch_idx];
            w_data  = pack_chan(PILE_FIELD_W'(pile_a[ch_idx]),
                                CHN_FIELD_W'(ch_idx),
                                VAL_FIELD_W'(peak_a[ch_idx]));
            if (ch_idx == CH_LAST) begin
               st_nx = ST_TRL;
            end else begin
               ch_nx = ch_idx + 1'b1;
            end
         end
         ST_TRL: begin
            w_valid = 1'b1;
            w_data  = pack_trl(event_count);
            st_nx   = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         ch_idx      <= '0;
         gate_q      <= 1'b0;
         arm         <= 1'b0;
         event_count <= '0;
      end else begin
         st     <= st_nx;
         ch_idx <= ch_nx;
         gate_q <= gate_any;
         if (full) begin
            arm <= 1'b0;
         end else if (arm_set) begin
            arm <= 1'b1;
         end else if (arm_clr) begin
            arm <= 1'b0;
         end
         if (st == ST_CAPT && !gate_any) begin
            event_count <= event_count + EVC_ONE;
         end
      end
   end

   evrec_store #(
      .ADDR_W      (ADDR_W),
      .FULL_MARGIN (FULL_MARGIN)
   ) i_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_valid (w_valid),
      .word       (w_data),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .wr_en      (wr_en),
      .half_full  (half_full),
      .full       (full)
   );

   // R12
   full_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> !arm);

   // R8
   evc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(event_count) |-> (event_count == $past(event_count) + EVC_ONE));

   // R9
   disarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && !arm) |=> (st == ST_IDLE));

   // R1
   hdr_then_ts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[26:24] == WK_HDR && !full) |=>
         (wr_en && wr_data[26:24] == WK_TSH));

endmodule

// File: tb/test_evrec_formatter.sv
module test_evrec_formatter;

   localparam int NCH = 8;
   localparam int AW  = 13;
   localparam int ADW = 7;
   localparam int TOPA = (1 << ADW) - 1;

   typedef struct packed {
      logic       ze;
      logic [7:0] mask;
      logic [12:0] base;
      logic [4:0] pulses;
      logic [7:0] uid;
      logic [1:0] gsel;
   } vec_t;

   localparam vec_t TBL [6] = '{
      '{ze:1'b0, mask:8'h04, base:13'd100,  pulses:5'd1, uid:8'hAA, gsel:2'd0},
      '{ze:1'b0, mask:8'h81, base:13'd2000, pulses:5'd3, uid:8'h5C, gsel:2'd1},
      '{ze:1'b1, mask:8'h10, base:13'd4000, pulses:5'd2, uid:8'h01, gsel:2'd0},
      '{ze:1'b0, mask:8'h00, base:13'd0,    pulses:5'd0, uid:8'hFF, gsel:2'd0},
      '{ze:1'b1, mask:8'h00, base:13'd0,    pulses:5'd0, uid:8'h33, gsel:2'd1},
      '{ze:1'b0, mask:8'hFF, base:13'd7000, pulses:5'd2, uid:8'hC3, gsel:2'd0}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              arm_set = 1'b0, arm_clr = 1'b0, arm;
   logic              ts_tick = 1'b0, ts_clr = 1'b0;
   logic              master_gate = 1'b0;
   logic [NCH-1:0]    chan_gate = '0;
   logic [NCH-1:0]    conv_valid = '0;
   logic [NCH*AW-1:0] conv_value = '0;
   logic [7:0]        user_id = '0;
   logic              zero_en = 1'b0;
   logic [ADW-1:0]    wr_addr;
   logic [31:0]       wr_data;
   logic              wr_en;
   logic [23:0]       event_count;
   logic              half_full, full;

   int n_cmp = 0;
   int n_mis = 0;
   int n_log = 0;
   int rd_ptr = 0;
   int exp_addr = 0;
   logic [23:0] exp_evc = '0;
   logic [47:0] exp_ts = '0;
   logic [31:0] log_d [256];
   int          log_a [256];

   always #4 clk = ~clk;

   evrec_formatter #(
      .NCH (NCH), .ADC_W (AW), .PILE_W (4), .ADDR_W (ADW), .FULL_MARGIN (10)
   ) i_evrec_formatter (
      .clk (clk), .rst_n (rst_n), .arm_set (arm_set), .arm_clr (arm_clr), .arm (arm),
      .ts_tick (ts_tick), .ts_clr (ts_clr), .master_gate (master_gate),
      .chan_gate (chan_gate), .conv_valid (conv_valid), .conv_value (conv_value),
      .user_id (user_id), .zero_en (zero_en), .wr_addr (wr_addr), .wr_data (wr_data),
      .wr_en (wr_en), .event_count (event_count), .half_full (half_full), .full (full)
   );

   always @(negedge clk) begin
      if (rst_n && wr_en && n_log < 256) begin
         log_d[n_log] = wr_data;
         log_a[n_log] = int'(wr_addr);
         n_log = n_log + 1;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      @(negedge clk) ts_tick = 1'b1;
      cyc(n);
      ts_tick = 1'b0;
      exp_ts = exp_ts + 48'(n);
   endtask

   task automatic pulse_set;
      @(negedge clk) arm_set = 1'b1;
      @(negedge clk) arm_set = 1'b0;
   endtask

   task automatic pulse_clr;
      @(negedge clk) arm_clr = 1'b1;
      @(negedge clk) arm_clr = 1'b0;
   endtask

   function automatic logic [12:0] vfun(input logic [12:0] base, input int c, input int k);
      if (k == 1) return base + 13'(c) + 13'd500;
      return base + 13'(c) + 13'(k);
   endfunction

   // gsel: 0 master gate, 1 channel gate, 2 both overlapping, 3 master with a late re-open
   task automatic run_event(input vec_t v);
      @(negedge clk);
      zero_en = v.ze;
      user_id = v.uid;
      if (v.gsel == 2'd1) chan_gate = 8'h40;
      else if (v.gsel == 2'd2) begin master_gate = 1'b1; chan_gate = 8'h02; end
      else master_gate = 1'b1;
      @(negedge clk);
      for (int k = 0; k < int'(v.pulses); k++) begin
         conv_valid = v.mask;
         for (int c = 0; c < NCH; c++) conv_value[c*AW +: AW] = vfun(v.base, c, k);
         @(negedge clk);
      end
      conv_valid = '0;
      if (v.gsel == 2'd2) begin
         chan_gate = '0;
         @(negedge clk);
      end
      @(negedge clk);
      master_gate = 1'b0;
      chan_gate = '0;
      if (v.gsel == 2'd3) begin
         cyc(3);
         master_gate = 1'b1;
         cyc(3);
         master_gate = 1'b0;
      end
      cyc(16);
   endtask

   task automatic take(input string tag, input logic [31:0] exp);
      if (exp_addr > TOPA) return;
      if (rd_ptr >= n_log) begin
         chk({tag, " missing word"}, 64'd0, 64'(exp));
      end else begin
         chk({tag, " word"}, 64'(log_d[rd_ptr]), 64'(exp));
         chk("R10 address", 64'(log_a[rd_ptr]), 64'(exp_addr));
         rd_ptr++;
      end
      exp_addr++;
   endtask

   task automatic expect_rec(input vec_t v, input string note);
      logic [3:0] cnt;
      logic [3:0] pile;
      logic [12:0] peak;
      bit hit;
      exp_evc = exp_evc + 24'd1;
      cnt = 4'd0;
      for (int c = 0; c < NCH; c++) if (v.mask[c] && v.pulses != 0) cnt++;
      if (v.ze) cnt = 4'd8;
      take({"R1 R2 header ", note}, {5'd0, 3'd2, v.uid, 4'd0, cnt, 8'd0});
      take({"R6 ts upper ", note}, {5'd0, 3'd5, exp_ts[47:24]});
      take({"R6 ts lower ", note}, {5'd0, 3'd6, exp_ts[23:0]});
      for (int c = 0; c < NCH; c++) begin
         hit = v.mask[c] && (v.pulses != 0);
         pile = (v.pulses > 15) ? 4'd15 : 4'(v.pulses);
         peak = (v.pulses >= 2) ? v.base + 13'(c) + 13'd500 : v.base + 13'(c);
         if (hit)
            take({"R3 channel ", note}, {pile, 1'b0, 3'd0, 5'd0, 3'(c), 3'd0, peak});
         else if (v.ze)
            take({"R5 idle channel ", note}, {4'd0, 1'b0, 3'd0, 5'd0, 3'(c), 3'd0, 13'd0});
      end
      take({"R8 trailer ", note}, {5'd0, 3'd4, exp_evc});
      chk({"R8 event count ", note}, 64'(event_count), 64'(exp_evc));
      chk({"R9 no extra write ", note}, 64'(n_log), 64'(rd_ptr));
      chk("R11 half_full", 64'(half_full), 64'(exp_addr >= 64));
      chk("R12 full", 64'(full), 64'(exp_addr > TOPA + 1 - 10));
   endtask

   initial begin
      #(8 * 150000);
      n_mis++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      vec_t v;
      int need;
      int k;
      cyc(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R14 reset state
      chk("R14 arm", 64'(arm), 64'd0);
      chk("R14 wr_en", 64'(wr_en), 64'd0);
      chk("R14 wr_addr", 64'(wr_addr), 64'd0);
      chk("R14 event_count", 64'(event_count), 64'd0);
      chk("R14 half_full", 64'(half_full), 64'd0);
      chk("R14 full", 64'(full), 64'd0);

      // R9: a gate while disarmed is ignored
      run_event(TBL[0]);
      chk("R9 disarmed writes", 64'(n_log), 64'd0);
      chk("R9 disarmed count", 64'(event_count), 64'd0);

      ticks(5);
      pulse_set;
      chk("R12 armed", 64'(arm), 64'd1);
      // R7: clear request while armed has no effect
      @(negedge clk) ts_clr = 1'b1;
      @(negedge clk) ts_clr = 1'b0;

      for (int i = 0; i < 6; i++) begin
         run_event(TBL[i]);
         expect_rec(TBL[i], $sformatf("R7 vec%0d", i));
         if (i == 2) begin
            // R10: disarm and re-arm keep the address
            pulse_clr;
            chk("R10 disarmed", 64'(arm), 64'd0);
            chk("R10 addr kept", 64'(wr_addr), 64'(exp_addr));
            pulse_set;
         end
         ticks(i * 3 + 1);
      end

      // R8: overlapping master and channel gates count once
      v = '{ze:1'b0, mask:8'h06, base:13'd300, pulses:5'd2, uid:8'h11, gsel:2'd2};
      run_event(v);
      expect_rec(v, "R8 overlap");

      // R4: saturating conversion count
      v = '{ze:1'b0, mask:8'h08, base:13'd900, pulses:5'd17, uid:8'h22, gsel:2'd0};
      run_event(v);
      expect_rec(v, "R4 saturation");

      // R9: gate reopening while the record is written
      v = '{ze:1'b0, mask:8'h20, base:13'd50, pulses:5'd1, uid:8'h44, gsel:2'd3};
      run_event(v);
      expect_rec(v, "R9 busy gate");

      // R7: clear honoured while disarmed
      pulse_clr;
      @(negedge clk) ts_clr = 1'b1;
      @(negedge clk) ts_clr = 1'b0;
      exp_ts = '0;
      pulse_set;
      v = '{ze:1'b0, mask:8'h02, base:13'd10, pulses:5'd1, uid:8'h55, gsel:2'd1};
      run_event(v);
      expect_rec(v, "R7 cleared");

      // pad to exactly FULL_MARGIN free locations
      while (exp_addr < TOPA + 1 - 10) begin
         need = TOPA + 1 - 10 - exp_addr;
         if (need >= 16) k = 12;
         else if (need >= 13) k = 8;
         else k = need;
         if (k == 12) v = '{ze:1'b1, mask:8'h00, base:13'd0, pulses:5'd0, uid:8'h66, gsel:2'd0};
         else v = '{ze:1'b0, mask:8'((1 << (k - 4)) - 1), base:13'd20, pulses:5'd1, uid:8'h77, gsel:2'd0};
         run_event(v);
         expect_rec(v, "R11 pad");
      end
      chk("R12 not yet full", 64'(full), 64'd0);
      chk("R12 still armed", 64'(arm), 64'd1);

      // R13: record runs into the top location and is cut there
      v = '{ze:1'b1, mask:8'h01, base:13'd60, pulses:5'd1, uid:8'h99, gsel:2'd0};
      run_event(v);
      expect_rec(v, "R13 top");
      chk("R13 last address", 64'(log_a[n_log-1]), 64'(TOPA));
      chk("R13 addr holds", 64'(wr_addr), 64'(TOPA));
      chk("R12 full set", 64'(full), 64'd1);
      chk("R12 disarmed by full", 64'(arm), 64'd0);
      pulse_set;
      chk("R12 re-arm refused", 64'(arm), 64'd0);
      run_event(TBL[0]);
      chk("R13 no write after top", 64'(n_log), 64'(rd_ptr));
      chk("R9 count after top", 64'(event_count), 64'(exp_evc));
      chk("R13 addr still holds", 64'(wr_addr), 64'(TOPA));

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

endmodule